// File: doc/BRIEF.md
# TDM Time Slot Router

This block steers the bits of serial time-division-multiplexed frames between two serial line ports and a small set of serial channel controllers. Each line port carries an independent receive frame and an independent transmit frame, so four frame sequencers run side by side. Each sequencer has its own frame-start pulse and its own bit clock. Every sequencer walks a host-written routing table one entry at a time. An entry names the channel that owns the slot, says how long the slot lasts in bits or in bytes, and can raise any of four strobe pins for the duration of the slot, whether or not the slot is routed to a channel.

A channel controller sees a one-cycle receive valid pulse with the sampled bit for every received bit that belongs to it. It sees a transmit enable level for every transmit bit period it owns, and the router drives its bit onto the owning line. When a transmit slot belongs to no channel, the line driver enable is low. A channel may take its receive bits from one line port and send on the other. Host writes land in a staging copy of the table, and a sequencer picks up its part of that copy only when its next frame start arrives.

The serial bit clocks and frame starts are sampled by the system clock `clk`. Each must stay high and low for at least one `clk` cycle.

Top module: `tdm_slot_router`

## Requirements
- R1: After reset, all channel valid pulses, channel transmit enables, line driver enables and strobe pins are 0.
- R2: A receive sequencer samples its line bit on the rising edge of its bit clock. In the next `clk` cycle only, the owning channel's `ch_rx_vld` bit is 1 and its `ch_rxd` bit carries the sample. Channels that do not own the bit show 0 on both.
- R3: A routing entry is 16 bits. Bits [15:12] are the strobe enables, bits [11:9] the channel number (0 means no channel, channel n drives bit n-1 of the channel vectors), bit 8 the unit (0 bits, 1 bytes), bits [7:3] the count minus one, and bit 1 marks the final entry. In bit units a slot lasts count+1 bit periods.
- R4: In byte units a slot lasts (count+1)x8 bit periods.
- R5: During every bit period of a slot, the strobe pins follow that entry's strobe enables. This holds even when the entry routes to no channel. Strobe pins are the OR over all four sequencers.
- R6: After the last bit of an entry marked final, or of the last entry of its table half, a sequencer routes nothing and strobes nothing until its next frame start.
- R7: A frame start sampled with a sequencer's active clock edge makes that bit the first bit of entry 0. This also applies in the middle of a frame.
- R8: A transmit sequencer advances on the falling edge of its bit clock. For the following bit period, the owning channel's `ch_tx_en` is 1 and that channel's `ch_txd` drives `line_txd`. `line_txd_oe` is 1 only while a valid channel owns the bit. Rising edges have no effect on transmit.
- R9: `host_tbl` selects the receive table (0) or the transmit table (1). Port A sequencers use entries 0 to 31 of their table, and port B sequencers use entries 32 to 63.
- R10: A host write reaches a sequencer only at that sequencer's next frame start. The frame in progress keeps the old entry.
- R11: Bit clock and frame start vectors are indexed as 0 port A receive, 1 port A transmit, 2 port B receive, 3 port B transmit. All four sequencers operate in the same `clk` cycle without interfering, and a channel may receive on one port and transmit on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe for a routing entry |
| host_tbl | input | 1 | Table select: 0 receive, 1 transmit |
| host_addr | input | 6 | Entry index within the selected table |
| host_wdata | input | 16 | Entry value |
| seq_clk | input | 4 | Bit clock per sequencer |
| seq_sync | input | 4 | Frame start per sequencer |
| line_rxd | input | 2 | Receive line data, port A bit 0, port B bit 1 |
| line_txd | output | 2 | Transmit line data per port |
| line_txd_oe | output | 2 | Transmit line driver enable per port |
| ch_txd | input | N_CH | Transmit bit from each channel controller |
| ch_rxd | output | N_CH | Received bit for each channel |
| ch_rx_vld | output | N_CH | One-cycle receive valid per channel |
| ch_tx_en | output | N_CH | Transmit bit-period enable per channel |
| strobe | output | N_STRB | Slot strobe pins |

## Verification
A receive edge on one port and a transmit edge on the other can land in the same `clk` cycle. Each updates different channel outputs, and both feed the shared strobe OR. The bench raises port B's receive clock and drops port A's transmit clock in the same `clk` cycle, with both frame starts asserted. Each table half holds a different channel and strobe pattern. The bench then checks that the receive pulse, the transmit enable, the line driver enable and the combined strobe value all appear together in the following cycle, each matching its own entry.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

   localparam int NSEQ   = 4;
   localparam int HOST_W = 16;
   localparam int CNT_W  = 8;

   // compact stored form of a routing entry (reserved bits dropped)
   typedef struct packed {
      logic [3:0] strb;
      logic [2:0] chan;
      logic       byte_unit;
      logic [4:0] cnt;
      logic       last;
   } tsa_entry_t;

   function automatic tsa_entry_t unpack_host(input logic [HOST_W-1:0] w);
      tsa_entry_t e;
      e.strb      = w[15:12];
      e.chan      = w[11:9];
      e.byte_unit = w[8];
      e.cnt       = w[7:3];
      e.last      = w[1];
      return e;
   endfunction

   // index of the final bit of a slot
   function automatic logic [CNT_W-1:0] slot_end(input tsa_entry_t e);
      return e.byte_unit ? {e.cnt, 3'b111} : {3'b000, e.cnt};
   endfunction

endpackage

// File: rtl/tsa_route_ram.sv
module tsa_route_ram
   import tsa_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int HALF = DEPTH / 2,
   localparam int IW   = $clog2(HALF)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      wr_tbl,
   input  logic [AW-1:0]             wr_addr,
   input  logic [HOST_W-1:0]         wr_data,
   input  logic [NSEQ-1:0]           load,
   input  logic [NSEQ-1:0][IW-1:0]   rd_idx,
   output tsa_entry_t [NSEQ-1:0]     rd_ent,
   output tsa_entry_t [NSEQ-1:0]     first_ent
);

   if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("tsa_route_ram: DEPTH must be a power of two of at least 4");
   end

   tsa_entry_t stg  [2][DEPTH];
   tsa_entry_t work [2][DEPTH];

   logic unused_rsv;
   assign unused_rsv = ^{wr_data[2], wr_data[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg  <= '{default: '0};
         work <= '{default: '0};
      end else begin
         if (wr_en) stg[wr_tbl][wr_addr] <= unpack_host(wr_data);
         for (int s = 0; s < NSEQ; s++) begin
            if (load[s]) begin
               for (int i = 0; i < HALF; i++) begin
                  work[s % 2][AW'((s / 2) * HALF + i)] <= stg[s % 2][AW'((s / 2) * HALF + i)];
               end
            end
         end
      end
   end

   for (genvar s = 0; s < NSEQ; s++) begin : g_rd
      localparam int TB   = s % 2;
      localparam int BASE = (s / 2) * HALF;
      assign rd_ent[s]    = work[TB][AW'(BASE) + AW'(rd_idx[s])];
      assign first_ent[s] = stg[TB][AW'(BASE)];
   end

endmodule

// File: rtl/tsa_seq.sv
module tsa_seq
   import tsa_pkg::*;
#(
   parameter bit  IS_TX = 1'b0,
   parameter int  HALF  = 32,
   localparam int IW    = $clog2(HALF)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sclk,
   input  logic          sync,
   input  logic          din,
   input  tsa_entry_t    ent,
   input  tsa_entry_t    first_ent,
   output logic [IW-1:0] idx_q,
   output logic          load,
   output logic [2:0]    chan_q,
   output logic [3:0]    strb_q,
   output logic          dout
);

   if (HALF < 2) begin : g_bad_half
      $error("tsa_seq: HALF must be at least 2");
   end

   logic sclk_d;
   always_ff @(posedge clk) sclk_d <= sclk;

   logic act;
   if (IS_TX) begin : g_fall
      assign act = sclk_d & ~sclk;
   end else begin : g_rise
      assign act = sclk & ~sclk_d;
   end

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   tsa_entry_t       cur;
   logic             live;
   logic [IW-1:0]    idx_now;
   logic [CNT_W-1:0] pos;
   logic             at_end;
   logic             is_final;

   always_comb begin
      live     = sync | run_q;
      cur      = sync ? first_ent : ent;
      idx_now  = sync ? '0 : idx_q;
      pos      = sync ? '0 : cnt_q;
      at_end   = (pos == slot_end(cur));
      is_final = cur.last | (idx_now == IW'(HALF - 1));
   end

   assign load = act & sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         idx_q  <= '0;
         cnt_q  <= '0;
         chan_q <= '0;
         strb_q <= '0;
      end else begin
         if (!IS_TX) chan_q <= '0;
         if (act) begin
            chan_q <= live ? cur.chan : 3'd0;
            strb_q <= live ? cur.strb : 4'd0;
            if (live) begin
               if (at_end) begin
                  cnt_q <= '0;
                  run_q <= ~is_final;
                  idx_q <= is_final ? idx_now : idx_now + 1'b1;
               end else begin
                  cnt_q <= pos + 1'b1;
                  run_q <= 1'b1;
                  idx_q <= idx_now;
               end
            end
         end
      end
   end

   if (IS_TX) begin : g_tx_data
      assign dout = din & (chan_q != 3'd0);
   end else begin : g_rx_data
      logic dat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   dat_q <= 1'b0;
         else if (act) dat_q <= din;
      end
      assign dout = dat_q;
   end

endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
   import tsa_pkg::*;
#(
   parameter int  N_CH      = 4,
   parameter int  N_STRB    = 4,
   parameter int  TBL_DEPTH = 64,
   localparam int AW        = $clog2(TBL_DEPTH),
   localparam int HALF      = TBL_DEPTH / 2,
   localparam int IW        = $clog2(HALF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_tbl,
   input  logic [AW-1:0]     host_addr,
   input  logic [15:0]       host_wdata,
   input  logic [3:0]        seq_clk,
   input  logic [3:0]        seq_sync,
   input  logic [1:0]        line_rxd,
   output logic [1:0]        line_txd,
   output logic [1:0]        line_txd_oe,
   input  logic [N_CH-1:0]   ch_txd,
   output logic [N_CH-1:0]   ch_rxd,
   output logic [N_CH-1:0]   ch_rx_vld,
   output logic [N_CH-1:0]   ch_tx_en,
   output logic [N_STRB-1:0] strobe
);

   if (N_CH < 1 || N_CH > 7) begin : g_bad_nch
      $error("tdm_slot_router: N_CH must be 1..7");
   end
   if (N_STRB < 1 || N_STRB > 4) begin : g_bad_nstrb
      $error("tdm_slot_router: N_STRB must be 1..4");
   end

   function automatic logic chan_ok(input logic [2:0] c);
      return (c != 3'd0) && (int'(c) <= N_CH);
   endfunction

   logic [NSEQ-1:0][IW-1:0] idx;
   logic [NSEQ-1:0]         load;
   logic [NSEQ-1:0][2:0]    chan;
   logic [NSEQ-1:0][3:0]    strb;
   logic [NSEQ-1:0]         din;
   logic [NSEQ-1:0]         dout;
   tsa_entry_t [NSEQ-1:0]   ent;
   tsa_entry_t [NSEQ-1:0]   first_ent;

   tsa_route_ram #(.DEPTH(TBL_DEPTH)) u_ram (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (host_we),
      .wr_tbl   (host_tbl),
      .wr_addr  (host_addr),
      .wr_data  (host_wdata),
      .load     (load),
      .rd_idx   (idx),
      .rd_ent   (ent),
      .first_ent(first_ent)
   );

   // transmit source: index 0 means no channel
   logic [7:0] tx_src;
   always_comb begin
      tx_src = '0;
      for (int c = 0; c < N_CH; c++) tx_src[c + 1] = ch_txd[c];
   end

   for (genvar s = 0; s < NSEQ; s++) begin : g_seq
      localparam bit TXS = (s % 2) == 1;
      if (TXS) begin : g_din_tx
         assign din[s] = tx_src[chan[s]];
      end else begin : g_din_rx
         assign din[s] = line_rxd[s / 2];
      end
      tsa_seq #(.IS_TX(TXS), .HALF(HALF)) u_seq (
         .clk      (clk),
         .rst_n    (rst_n),
         .sclk     (seq_clk[s]),
         .sync     (seq_sync[s]),
         .din      (din[s]),
         .ent      (ent[s]),
         .first_ent(first_ent[s]),
         .idx_q    (idx[s]),
         .load     (load[s]),
         .chan_q   (chan[s]),
         .strb_q   (strb[s]),
         .dout     (dout[s])
      );
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      localparam logic [2:0] CID = 3'(c + 1);
      logic hit_a, hit_b;
      assign hit_a        = (chan[0] == CID);
      assign hit_b        = (chan[2] == CID);
      assign ch_rx_vld[c] = hit_a | hit_b;
      assign ch_rxd[c]    = hit_a ? dout[0] : (hit_b & dout[2]);
      assign ch_tx_en[c]  = (chan[1] == CID) | (chan[3] == CID);
   end

   for (genvar p = 0; p < 2; p++) begin : g_line
      assign line_txd_oe[p] = chan_ok(chan[2 * p + 1]);
      assign line_txd[p]    = dout[2 * p + 1] & line_txd_oe[p];
   end

   logic [3:0] strb_or;
   always_comb begin
      strb_or = '0;
      for (int s = 0; s < NSEQ; s++) strb_or |= strb[s];
   end
   assign strobe = strb_or[N_STRB-1:0];

endmodule

// File: rtl/tdm_slot_router_chk.sv
module tdm_slot_router_chk #(
   parameter int N_CH   = 4,
   parameter int N_STRB = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        seq_clk,
   input logic [1:0]        line_txd_oe,
   input logic [N_CH-1:0]   ch_rx_vld,
   input logic [N_CH-1:0]   ch_tx_en,
   input logic [N_STRB-1:0] strobe
);

   // a receive pulse only follows a rising bit clock on a receive sequencer
   p_rxvld_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_rx_vld != '0) |->
         (($past(seq_clk[0]) && !$past(seq_clk[0], 2)) ||
          ($past(seq_clk[2]) && !$past(seq_clk[2], 2))))
      else $error("p_rxvld_after_rise_r2");

   // port A driver enable changes only after a falling transmit clock
   p_oe_a_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_txd_oe[0]) |-> ($past(seq_clk[1], 2) && !$past(seq_clk[1])))
      else $error("p_oe_a_on_fall_r8");

   p_oe_b_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_txd_oe[1]) |-> ($past(seq_clk[3], 2) && !$past(seq_clk[3])))
      else $error("p_oe_b_on_fall_r8");

   // a driven line always has an owning channel enabled
   p_oe_needs_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (line_txd_oe != 2'b00) |-> (ch_tx_en != '0))
      else $error("p_oe_needs_owner_r8");

   // strobes move only after some bit clock edge
   p_strobe_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(strobe) |-> ($past(seq_clk) != $past(seq_clk, 2)))
      else $error("p_strobe_on_edge_r5");

   // transmit enables move only after a falling transmit clock
   p_txen_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ch_tx_en) |->
         (($past(seq_clk[1], 2) && !$past(seq_clk[1])) ||
          ($past(seq_clk[3], 2) && !$past(seq_clk[3]))))
      else $error("p_txen_on_fall_r11");

endmodule

bind tdm_slot_router tdm_slot_router_chk #(.N_CH(N_CH), .N_STRB(N_STRB)) u_chk (.*);

// File: tb/test_tdm_slot_router.sv
module test_tdm_slot_router;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0;
   logic       host_tbl = 1'b0;
   logic [5:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [3:0] seq_clk = '0;
   logic [3:0] seq_sync = '0;
   logic [1:0] line_rxd = '0;
   logic [1:0] line_txd, line_txd_oe;
   logic [3:0] ch_txd = '0;
   logic [3:0] ch_rxd, ch_rx_vld, ch_tx_en, strobe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tdm_slot_router i_tdm_slot_router (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_tbl(host_tbl),
      .host_addr(host_addr), .host_wdata(host_wdata), .seq_clk(seq_clk),
      .seq_sync(seq_sync), .line_rxd(line_rxd), .line_txd(line_txd),
      .line_txd_oe(line_txd_oe), .ch_txd(ch_txd), .ch_rxd(ch_rxd),
      .ch_rx_vld(ch_rx_vld), .ch_tx_en(ch_tx_en), .strobe(strobe)
   );

   // {sync, rxd, vld[3:0], strobe[3:0]} per port A receive bit
   localparam logic [9:0] RX_VEC [14] = '{
      10'b1_1_0001_0001, 10'b0_0_0001_0001, 10'b0_1_0000_0010,
      10'b0_1_0010_0100, 10'b0_0_0010_0100, 10'b0_1_0010_0100,
      10'b0_1_0010_0100, 10'b0_0_0010_0100, 10'b0_0_0010_0100,
      10'b0_1_0010_0100, 10'b0_0_0010_0100, 10'b0_1_0100_0000,
      10'b0_1_0000_0000, 10'b0_0_0000_0000
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic tbl, input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      host_we = 1'b1; host_tbl = tbl; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   // change bit clocks and frame starts; return one cycle after they are sampled
   task automatic step(input logic [3:0] clkv, input logic [3:0] syn);
      @(negedge clk);
      seq_clk = clkv; seq_sync = syn;
      @(negedge clk);
      seq_sync = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog act=running exp=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset rx_vld", 32'(ch_rx_vld), 0);
      chk("R1 reset tx_en", 32'(ch_tx_en), 0);
      chk("R1 reset oe", 32'(line_txd_oe), 0);
      chk("R1 reset strobe", 32'(strobe), 0);

      // port A receive table: ch1 2 bits, none 1 bit strobe, ch2 one byte, ch3 final
      wr(1'b0, 6'd0, 16'h1208);
      wr(1'b0, 6'd1, 16'h2000);
      wr(1'b0, 6'd2, 16'h4500);
      wr(1'b0, 6'd3, 16'h0602);

      // R2 R3 R4 R5 R6 R10: table walk, entry 3 rewritten mid-frame
      for (int i = 0; i < 14; i++) begin
         logic [9:0] v;
         v = RX_VEC[i];
         if (i == 5) wr(1'b0, 6'd3, 16'h0802);
         line_rxd[0] = v[8];
         step(seq_clk | 4'b0001, v[9] ? 4'b0001 : 4'b0000);
         chk($sformatf("R2/R3/R4 vld bit%0d", i), 32'(ch_rx_vld), 32'(v[7:4]));
         chk($sformatf("R2 rxd bit%0d", i), 32'(ch_rxd), 32'(v[8] ? v[7:4] : 4'b0000));
         chk($sformatf("R5/R6 strobe bit%0d", i), 32'(strobe), 32'(v[3:0]));
         step(seq_clk & ~4'b0001, 4'b0000);
         if (i == 0) chk("R2 pulse gone", 32'(ch_rx_vld), 0);
      end

      // R10: rewritten entry takes effect in the next frame
      for (int i = 0; i < 12; i++) begin
         step(seq_clk | 4'b0001, i == 0 ? 4'b0001 : 4'b0000);
         if (i == 11) chk("R10 new entry", 32'(ch_rx_vld), 32'h8);
         step(seq_clk & ~4'b0001, 4'b0000);
      end

      // R7: frame start in the middle of a frame restarts at entry 0
      for (int i = 0; i < 16; i++) begin
         step(seq_clk | 4'b0001, (i == 0 || i == 3) ? 4'b0001 : 4'b0000);
         if (i == 3) chk("R7 restart vld", 32'(ch_rx_vld), 32'h1);
         if (i == 3) chk("R7 restart strobe", 32'(strobe), 32'h1);
         if (i == 5) chk("R7 R3 entry1 strobe", 32'(strobe), 32'h2);
         step(seq_clk & ~4'b0001, 4'b0000);
      end
      chk("R6 idle strobe", 32'(strobe), 0);

      // R8 R9 R11: port B transmit, ch2 for two bits, final
      wr(1'b1, 6'd32, 16'h040A);
      ch_txd = 4'b0010;
      step(seq_clk | 4'b1000, 4'b0000);
      chk("R8 rise ignored", 32'(ch_tx_en), 0);
      step(seq_clk & ~4'b1000, 4'b1000);
      chk("R8 tx_en", 32'(ch_tx_en), 32'h2);
      chk("R8 oe", 32'(line_txd_oe), 32'h2);
      chk("R8 txd", 32'(line_txd), 32'h2);
      @(negedge clk); ch_txd = 4'b0000; #1;
      chk("R8 txd follows channel", 32'(line_txd), 0);
      step(seq_clk | 4'b1000, 4'b0000);
      step(seq_clk & ~4'b1000, 4'b0000);
      chk("R8 second bit", 32'(ch_tx_en), 32'h2);
      step(seq_clk | 4'b1000, 4'b0000);
      step(seq_clk & ~4'b1000, 4'b0000);
      chk("R8 R6 tx done en", 32'(ch_tx_en), 0);
      chk("R8 tx done oe", 32'(line_txd_oe), 0);

      // R11 R9: port B receive and port A transmit in the same cycle
      wr(1'b0, 6'd32, 16'h8202);
      wr(1'b1, 6'd0, 16'h1602);
      step(seq_clk | 4'b0010, 4'b0000);
      line_rxd[1] = 1'b1;
      ch_txd = 4'b0100;
      step((seq_clk & ~4'b0010) | 4'b0100, 4'b0110);
      chk("R11 R9 rx vld", 32'(ch_rx_vld), 32'h1);
      chk("R11 rx data", 32'(ch_rxd), 32'h1);
      chk("R11 tx en", 32'(ch_tx_en), 32'h4);
      chk("R11 oe", 32'(line_txd_oe), 32'h1);
      chk("R11 txd", 32'(line_txd), 32'h1);
      chk("R11 R5 strobe or", 32'(strobe), 32'h9);
      @(negedge clk);
      chk("R2 one-cycle pulse", 32'(ch_rx_vld), 0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule